// File: doc/BRIEF.md
# Halt and Wakeup Controller with Oscillator Settling Delay

This block decides when the processor core gets its clock. A software write of a one to the halt control bit stops the core clock, and the core then keeps its state exactly. The clock is restored by one of three events. The first is a rising edge on the restart pin. The second is a rising edge on the request line from the multi-input wakeup unit. The third is the external reset.

The restart pin doubles as the oscillator output when the crystal clock option is selected, so in that option its edges are ignored. A wakeup exit in crystal mode does not release the clock at once. It first loads the start-up timer, which is the reused watchdog prescaler, with its full value. The clock comes back only after 256 instruction cycles, where one instruction cycle is ten oscillator clocks. A reset exit, and any exit under the external or RC option, skips this delay. Every non-reset exit still pulses a reload strobe, because the watchdog prescaler and counter contents are overwritten in every clock option.

The controller has three states. RUN means the core is clocked. HALT means the core is frozen and waiting. SETTLE means the oscillator is settling after a crystal-mode wakeup. The named transitions are as follows. ENTER (RUN to HALT) happens on a halt write. RESUME (HALT to RUN) happens on a restart or wakeup edge in the external or RC option. WARMUP (HALT to SETTLE) happens on a wakeup edge in the crystal option. RELEASE (SETTLE to RUN) happens when the timer expires. RESET takes any state to RUN. The resume-select output tells the core to fetch from the reset vector 0x0000 (value 0) or from the instruction after the halt (value 1).

Top module: `hw_halt_ctrl`

## Requirements
- R1: While and after reset, core_clk_en is 1, resume_next is 0 (resume at address 0x0000) and wdt_reload is 0.
- R2: A halt_wr pulse sampled in RUN drops core_clk_en after that clock edge. It stays 0 until an exit event occurs.
- R3: With clk_opt 2'b01 (external) or 2'b10 (RC), a rising edge on restart_pin during HALT raises core_clk_en on the third clock edge after the pin rises. It also sets resume_next to 1.
- R4: With clk_opt 2'b00 (crystal), restart_pin edges have no effect during HALT. core_clk_en stays 0.
- R5: With the external or RC option, a rising edge on wake_req during HALT restores core_clk_en with the same three-edge latency as R3, and sets resume_next to 1.
- R6: With the crystal option, a wake_req rising edge during HALT enters SETTLE on the third edge. core_clk_en stays 0 for SETTLE_TICKS*TICK_DIV (2560) further edges and rises on the last of them.
- R7: wdt_reload is a one-cycle pulse on the edge that leaves HALT by restart or wakeup, in every clock option.
- R8: Reset asserted in HALT or SETTLE restores core_clk_en immediately, with resume_next 0, no settling delay and no reload pulse.
- R9: Only rising edges act. A restart or wake level held high triggers nothing further, and edges seen while in RUN change no output.
- R10: clk_opt 2'b11 behaves like the external option.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| clk_opt | input | 2 | Clock option: 00 crystal, 01 external, 10 RC, 11 as external |
| halt_wr | input | 1 | Software write of one to the halt control bit |
| restart_pin | input | 1 | Asynchronous restart pin |
| wake_req | input | 1 | Asynchronous request from the multi-input wakeup unit |
| core_clk_en | output | 1 | Core clock enable |
| resume_next | output | 1 | 1: resume after the halt instruction; 0: resume at 0x0000 |
| wdt_reload | output | 1 | Pulse: watchdog prescaler and counter loaded with all ones |

## Verification
The assertions assume that clk_opt does not change while the controller is in HALT or SETTLE. They also assume that halt_wr is meaningful only in RUN, and that restart and wake levels stay stable for at least two clocks so the synchroniser sees clean edges. The stimulus changes clk_opt only while the core runs. It holds every pin pulse for three clocks and drives all inputs two nanoseconds after a rising edge. It compares a queue-based behavioural model on every falling edge, and it adds directed checks at the cycles where each transition is expected.

// File: rtl/hw_halt_pkg.sv
package hw_halt_pkg;
    typedef enum logic [1:0] {
        HS_RUN    = 2'b00,
        HS_HALT   = 2'b01,
        HS_SETTLE = 2'b10
    } hw_state_e;

    localparam logic [1:0] OPT_CRYSTAL  = 2'b00;
    localparam logic [1:0] OPT_EXTERNAL = 2'b01;
    localparam logic [1:0] OPT_RC       = 2'b10;
endpackage

// File: rtl/hw_edge_sync.sv
module hw_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;

    // R9
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/hw_tick_div.sv
module hw_tick_div #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + W'(1);
    end

    assign tick = run && (cnt == LAST);

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/hw_settle_timer.sv
module hw_settle_timer #(
    parameter int TICKS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic done
);
    localparam int W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [W-1:0] FULL = W'(TICKS - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= FULL;
        else if (load)                cnt <= FULL;
        else if (tick && cnt != '0)   cnt <= cnt - W'(1);
    end

    assign done = tick && !load && (cnt == '0);

    // R6
    settle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == FULL);

    // R6
    settle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt != '0) |=> cnt == $past(cnt) - W'(1));
endmodule

// File: rtl/hw_halt_ctrl.sv
module hw_halt_ctrl
    import hw_halt_pkg::*;
#(
    parameter int TICK_DIV     = 10,
    parameter int SETTLE_TICKS = 256,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_opt,
    input  logic       halt_wr,
    input  logic       restart_pin,
    input  logic       wake_req,
    output logic       core_clk_en,
    output logic       resume_next,
    output logic       wdt_reload
);
    hw_state_e state, nxt;
    logic restart_rise, wake_rise;
    logic tick, done, load, leave;
    logic resume_q, reload_q;
    logic is_xtal;

    assign is_xtal = (clk_opt == OPT_CRYSTAL);

    hw_edge_sync #(.STAGES(SYNC_STAGES)) i_restart_sync (
        .clk(clk), .rst_n(rst_n), .pin(restart_pin), .rise(restart_rise));

    hw_edge_sync #(.STAGES(SYNC_STAGES)) i_wake_sync (
        .clk(clk), .rst_n(rst_n), .pin(wake_req), .rise(wake_rise));

    hw_tick_div #(.DIV(TICK_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .run(state == HS_SETTLE), .tick(tick));

    hw_settle_timer #(.TICKS(SETTLE_TICKS)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .tick(tick), .done(done));

    always_comb begin
        nxt   = state;
        load  = 1'b0;
        leave = 1'b0;
        unique case (state)
            HS_RUN: begin
                if (halt_wr) nxt = HS_HALT;
            end
            HS_HALT: begin
                if (is_xtal) begin
                    if (wake_rise) begin
                        nxt   = HS_SETTLE;
                        load  = 1'b1;
                        leave = 1'b1;
                    end
                end else if (wake_rise || restart_rise) begin
                    nxt   = HS_RUN;
                    leave = 1'b1;
                end
            end
            HS_SETTLE: begin
                if (done) nxt = HS_RUN;
            end
            default: nxt = HS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_RUN;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resume_q <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            reload_q <= leave;
            if (leave) resume_q <= 1'b1;
        end
    end

    always_comb begin
        core_clk_en = (state == HS_RUN);
        resume_next = resume_q;
        wdt_reload  = reload_q;
    end

    // R2
    halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_RUN && halt_wr) |=> !core_clk_en);

    // R3
    restart_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_xtal && state == HS_HALT && restart_rise) |=> (core_clk_en && resume_next));

    // R4
    xtal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_xtal && state == HS_HALT) |=> !core_clk_en);

    // R5
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_xtal && state == HS_HALT && wake_rise) |=> core_clk_en);

    // R6
    warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_xtal && state == HS_HALT && wake_rise) |=> (!core_clk_en && wdt_reload));

    // R7
    reload_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reload |-> $past(state == HS_HALT));
endmodule

// File: tb/test_hw_halt_ctrl.sv
module test_hw_halt_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_opt = 2'b01;
    logic       halt_wr = 1'b0;
    logic       restart_pin = 1'b0;
    logic       wake_req = 1'b0;
    logic       core_clk_en, resume_next, wdt_reload;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    localparam int SETTLE_CYC = 256 * 10;

    always #10 clk = ~clk;

    hw_halt_ctrl i_hw_halt_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_opt(clk_opt), .halt_wr(halt_wr),
        .restart_pin(restart_pin), .wake_req(wake_req),
        .core_clk_en(core_clk_en), .resume_next(resume_next), .wdt_reload(wdt_reload));

    // behavioural reference model: 0 run, 1 halted, 2 settling
    int m_state;
    int m_left;
    bit m_resume, m_reload;
    bit rq[$];
    bit wq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_left = 0; m_resume = 0; m_reload = 0;
            rq = '{0, 0, 0, 0};
            wq = '{0, 0, 0, 0};
        end else begin
            bit r_edge, w_edge;
            rq.push_front(restart_pin); void'(rq.pop_back());
            wq.push_front(wake_req);    void'(wq.pop_back());
            r_edge = rq[2] && !rq[3];
            w_edge = wq[2] && !wq[3];
            m_reload = 0;
            case (m_state)
                0: if (halt_wr) m_state = 1;
                1: begin
                    if (clk_opt == 2'b00) begin
                        if (w_edge) begin
                            m_state = 2; m_left = SETTLE_CYC;
                            m_reload = 1; m_resume = 1;
                        end
                    end else if (w_edge || r_edge) begin
                        m_state = 0; m_reload = 1; m_resume = 1;
                    end
                end
                default: begin
                    m_left--;
                    if (m_left == 0) m_state = 0;
                end
            endcase
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk(cur_req, core_clk_en, (m_state == 0), "model core_clk_en");
        chk(cur_req, resume_next, m_resume, "model resume_next");
        chk(cur_req, wdt_reload, m_reload, "model wdt_reload");
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_halt();
        halt_wr = 1'b1; step(1); halt_wr = 1'b0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        cur_req = "R1";
        chk("R1", core_clk_en, 1, "clock during reset");
        rst_n = 1'b1; step(2);
        chk("R1", core_clk_en, 1, "clock after reset");
        chk("R1", resume_next, 0, "resume vector after reset");
        chk("R1", wdt_reload, 0, "reload after reset");

        // R9: edges while running change nothing
        cur_req = "R9";
        restart_pin = 1; step(3); restart_pin = 0; step(3);
        chk("R9", core_clk_en, 1, "run edge clock");
        chk("R9", resume_next, 0, "run edge resume");

        // R2 + R3: external option, restart exit
        cur_req = "R2"; clk_opt = 2'b01;
        do_halt();
        chk("R2", core_clk_en, 0, "halted");
        step(5);
        chk("R2", core_clk_en, 0, "still halted");
        cur_req = "R3";
        restart_pin = 1; step(2);
        chk("R3", core_clk_en, 0, "before sync latency");
        step(1);
        chk("R3", core_clk_en, 1, "restart exit");
        chk("R3", resume_next, 1, "resume after halt");
        chk("R7", wdt_reload, 1, "reload on restart exit");
        step(1);
        chk("R7", wdt_reload, 0, "reload one cycle");
        restart_pin = 0; step(2);

        // R5: RC option, wake exit
        cur_req = "R5"; clk_opt = 2'b10;
        do_halt(); step(4);
        wake_req = 1; step(3);
        chk("R5", core_clk_en, 1, "wake exit RC");
        wake_req = 0; step(2);

        // R9: held level does not retrigger
        cur_req = "R9"; clk_opt = 2'b01;
        do_halt(); step(2);
        wake_req = 1; step(3);
        chk("R9", core_clk_en, 1, "exit on edge");
        step(2);
        do_halt(); step(20);
        chk("R9", core_clk_en, 0, "held level ignored");
        wake_req = 0; step(3); wake_req = 1; step(3);
        chk("R9", core_clk_en, 1, "fresh edge exits");
        wake_req = 0; step(2);

        // R10: option 11 as external
        cur_req = "R10"; clk_opt = 2'b11;
        do_halt(); step(3);
        restart_pin = 1; step(3);
        chk("R10", core_clk_en, 1, "option 11 restart exit");
        restart_pin = 0; step(2);

        // R4 + R6: crystal option
        cur_req = "R4"; clk_opt = 2'b00;
        do_halt(); step(2);
        restart_pin = 1; step(3); restart_pin = 0; step(20);
        chk("R4", core_clk_en, 0, "restart ignored in crystal");
        chk("R4", wdt_reload, 0, "no reload on ignored restart");
        cur_req = "R6";
        wake_req = 1; step(3);
        chk("R6", core_clk_en, 0, "settling starts");
        chk("R7", wdt_reload, 1, "reload on warmup");
        wake_req = 0;
        step(SETTLE_CYC - 1);
        chk("R6", core_clk_en, 0, "one cycle before release");
        step(1);
        chk("R6", core_clk_en, 1, "released after delay");
        chk("R6", resume_next, 1, "resume after halt");
        step(3);

        // R8: reset from halt, then from settle
        cur_req = "R8";
        do_halt(); step(4);
        rst_n = 0; #1;
        chk("R8", core_clk_en, 1, "reset from halt");
        chk("R8", resume_next, 0, "reset vector");
        step(2); rst_n = 1; step(2);
        chk("R8", wdt_reload, 0, "no reload on reset exit");
        do_halt(); step(2);
        wake_req = 1; step(3); wake_req = 0; step(100);
        chk("R8", core_clk_en, 0, "in settle");
        rst_n = 0; #1;
        chk("R8", core_clk_en, 1, "reset from settle");
        step(2); rst_n = 1; step(5);
        chk("R8", core_clk_en, 1, "running after reset");
        chk("R8", resume_next, 0, "vector after settle reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule